// File: doc/BRIEF.md
# IEC60958 Subframe Word Packer

This block takes an interleaved stream of audio samples, between two and eight channels per frame, and turns each sample into a 32-bit transmitter word laid out as an IEC60958 subframe. The word carries the sample in bits 23..0 and the V, U, C, P and B flags in bits 24..28. A downstream serializer can then send the word without further bit shuffling.

In 24-bit PCM mode the packer builds the flags itself. It keeps a 192-frame channel-status position that all channels of a frame share. From a 32-bit consumer status word it picks the channel-status bit for the current frame. In each channel's copy of that word, status bits 23..20 are replaced by the channel number. The packer marks the block start and computes even parity. In pass-through mode the input words are already complete subframes, and the packer only moves their fields to the output positions.

Both sides use valid/ready handshakes, and the output is registered. Configuration inputs are held steady while a stream runs. A synchronous restart input sets the frame and channel position back to zero at the start of a stream.

Top module: `iec_subframe_packer`

## Requirements
- R1: In PCM mode, output bits 23..0 equal input bits 23..0, input bits 31..24 are discarded, and output bits 31..29 are always 0 in both modes.
- R2: In PCM mode, V (output bit 24) and U (output bit 25) are 0.
- R3: In PCM mode, C (output bit 26) of a word in frame f (0..191) is bit f of `cfg_status` for f < 32, where bit 8*n+j is bit j of status byte n, and C is 0 for frames 32..191.
- R4: For frames 20..23 the C bit instead comes from the 4-bit channel number (channel position + 1), with frame 20 carrying its least significant bit, so channel 0 sends 1.
- R5: In PCM mode, P (output bit 27) is chosen so that output bits 27..0 hold an even number of ones.
- R6: In PCM mode, B (output bit 28) is 1 only on channel position 0 of frame 0.
- R7: The channel position advances on each accepted input word. After the last channel of a frame it returns to 0, and the frame index advances, wrapping from 191 to 0.
- R8: In pass-through mode (`cfg_mode` = 1), input bits 27..4 go to output bits 23..0, input bits 31..28 go to output bits 27..24, and input bit 3 goes to output bit 28.
- R9: A `cfg_chans` value below 2 is treated as 2, and a value above 8 is treated as 8.
- R10: A cycle with `restart` high accepts no input, empties the output register, and sets channel position and frame index to 0, so any partial frame is discarded.
- R11: Words leave in input order with none lost or duplicated. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous stream restart |
| cfg_mode | input | 1 | 0 = 24-bit PCM, 1 = pass-through |
| cfg_chans | input | 4 | Channels per frame (clamped to 2..8) |
| cfg_status | input | 32 | Consumer channel-status bytes, byte 0 in bits 7..0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input sample or prebuilt subframe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Packed subframe word |

## Verification
Two things can land in the same cycle: the frame boundary, where the last channel of a frame is accepted and the frame index steps or wraps, and output backpressure, which holds the current word while the next input waits. The bench forces this overlap by streaming hundreds of frames at several channel counts with `out_ready` low one cycle in three. Every word received is compared with a model that works out channel and frame from its position in the stream. A wrong step at a stalled boundary therefore shows up as a misplaced B or C bit. A restart is also given while a word is still held in the output register, and the first word after it must come out as channel 0 of frame 0.

// File: rtl/iec_pack_pkg.sv
package iec_pack_pkg;
  localparam int WORD_W    = 32;
  localparam int SAMPLE_W  = 24;
  localparam int V_BIT     = 24;
  localparam int U_BIT     = 25;
  localparam int C_BIT     = 26;
  localparam int P_BIT     = 27;
  localparam int B_BIT     = 28;
  localparam int CS_BITS   = 32;
  localparam int CHNUM_LO  = 20;
  localparam int CHNUM_W   = 4;
  // pass-through source positions
  localparam int PT_FLAGS_LO  = 28;
  localparam int PT_SAMPLE_LO = 4;
  localparam int PT_BLOCK_BIT = 3;

  typedef enum logic {
    MODE_PCM  = 1'b0,
    MODE_PASS = 1'b1
  } pack_mode_e;
endpackage

// File: rtl/iec_frame_tracker.sv
module iec_frame_tracker #(
  parameter int MAX_CH = 8,
  parameter int MIN_CH = 2,
  parameter int FRAMES = 192
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         restart,
  input  logic                         step,
  input  logic [$clog2(MAX_CH+1)-1:0]  cfg_chans,
  output logic [$clog2(MAX_CH)-1:0]    ch_pos,
  output logic [$clog2(FRAMES)-1:0]    frame_idx
);
  localparam int CNT_W = $clog2(MAX_CH+1);
  localparam int POS_W = $clog2(MAX_CH);
  localparam int FR_W  = $clog2(FRAMES);

  logic [CNT_W-1:0] n_eff;
  logic             last_ch;
  logic             last_frame;

  always_comb begin
    if (cfg_chans < CNT_W'(MIN_CH))      n_eff = CNT_W'(MIN_CH);
    else if (cfg_chans > CNT_W'(MAX_CH)) n_eff = CNT_W'(MAX_CH);
    else                                 n_eff = cfg_chans;
  end

  assign last_ch    = (CNT_W'(ch_pos) == (n_eff - CNT_W'(1)));
  assign last_frame = (frame_idx == FR_W'(FRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ch_pos    <= '0;
      frame_idx <= '0;
    end else if (step) begin
      if (last_ch) begin
        ch_pos    <= '0;
        frame_idx <= last_frame ? '0 : frame_idx + FR_W'(1);
      end else begin
        ch_pos <= ch_pos + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/iec_status_select.sv
module iec_status_select
  import iec_pack_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int FRAMES = 192
) (
  input  logic [CS_BITS-1:0]         cfg_status,
  input  logic [$clog2(MAX_CH)-1:0]  ch_pos,
  input  logic [$clog2(FRAMES)-1:0]  frame_idx,
  output logic                       c_bit
);
  localparam int FR_W  = $clog2(FRAMES);
  localparam int IDX_W = $clog2(CS_BITS);
  localparam logic [CS_BITS-1:0] NUM_MASK =
    ((CS_BITS'(1) << CHNUM_W) - CS_BITS'(1)) << CHNUM_LO;

  // one status image per channel, number field replaced by position + 1
  logic [CS_BITS-1:0] cs_tab [MAX_CH];

  for (genvar g = 0; g < MAX_CH; g++) begin : g_chan
    assign cs_tab[g] = (cfg_status & ~NUM_MASK) |
                       (CS_BITS'(g + 1) << CHNUM_LO);
  end

  logic [CS_BITS-1:0] sel_vec;
  assign sel_vec = cs_tab[ch_pos];

  always_comb begin
    if (frame_idx < FR_W'(CS_BITS)) c_bit = sel_vec[frame_idx[IDX_W-1:0]];
    else                            c_bit = 1'b0;
  end
endmodule

// File: rtl/iec_word_former.sv
module iec_word_former
  import iec_pack_pkg::*;
(
  input  pack_mode_e        mode,
  input  logic [WORD_W-1:0] din,
  input  logic              c_bit,
  input  logic              b_flag,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    if (mode == MODE_PCM) begin
      word[SAMPLE_W-1:0] = din[SAMPLE_W-1:0];
      word[V_BIT]        = 1'b0;
      word[U_BIT]        = 1'b0;
      word[C_BIT]        = c_bit;
      word[B_BIT]        = b_flag;
      word[P_BIT]        = ^word[C_BIT:0];
    end else begin
      word[SAMPLE_W-1:0] = din[PT_SAMPLE_LO +: SAMPLE_W];
      word[P_BIT:V_BIT]  = din[WORD_W-1:PT_FLAGS_LO];
      word[B_BIT]        = din[PT_BLOCK_BIT];
    end
  end
endmodule

// File: rtl/iec_subframe_packer.sv
module iec_subframe_packer
  import iec_pack_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int MIN_CH = 2,
  parameter int FRAMES = 192
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         restart,
  input  logic                         cfg_mode,
  input  logic [$clog2(MAX_CH+1)-1:0]  cfg_chans,
  input  logic [31:0]                  cfg_status,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [31:0]                  in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [31:0]                  out_data
);
  localparam int POS_W = $clog2(MAX_CH);
  localparam int FR_W  = $clog2(FRAMES);

  logic [POS_W-1:0]  trk_ch;
  logic [FR_W-1:0]   trk_frame;
  logic              in_fire;
  logic              c_bit;
  logic              b_flag;
  logic [WORD_W-1:0] word_nxt;

  assign in_ready = (!out_valid || out_ready) && !restart;
  assign in_fire  = in_valid && in_ready;
  assign b_flag   = (trk_ch == '0) && (trk_frame == '0);

  iec_frame_tracker #(
    .MAX_CH(MAX_CH), .MIN_CH(MIN_CH), .FRAMES(FRAMES)
  ) trk_i (
    .clk(clk), .rst(rst), .restart(restart), .step(in_fire),
    .cfg_chans(cfg_chans), .ch_pos(trk_ch), .frame_idx(trk_frame)
  );

  iec_status_select #(
    .MAX_CH(MAX_CH), .FRAMES(FRAMES)
  ) sel_i (
    .cfg_status(cfg_status), .ch_pos(trk_ch), .frame_idx(trk_frame),
    .c_bit(c_bit)
  );

  iec_word_former form_i (
    .mode(pack_mode_e'(cfg_mode)), .din(in_data), .c_bit(c_bit),
    .b_flag(b_flag), .word(word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (restart) begin
      out_valid <= 1'b0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_data  <= word_nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iec_subframe_packer_chk.sv
module iec_subframe_packer_chk #(
  parameter int MAX_CH = 8,
  parameter int FRAMES = 192
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        restart,
  input logic                        cfg_mode,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [31:0]                 out_data,
  input logic [$clog2(MAX_CH)-1:0]   ch_pos,
  input logic [$clog2(FRAMES)-1:0]   frame_idx
);
  // R1
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data[31:29] == 3'b000);
  // R2
  vu_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_mode) |-> out_data[25:24] == 2'b00);
  // R5
  even_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_mode) |-> (^out_data[27:0]) == 1'b0);
  // R7
  frame_range_chk: assert property (@(posedge clk) disable iff (rst)
    frame_idx < ($clog2(FRAMES))'(FRAMES));
  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!out_valid && frame_idx == '0 && ch_pos == '0));
  // R10
  restart_block_chk: assert property (@(posedge clk) disable iff (rst)
    restart |-> !in_ready);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !restart) |=> (out_valid && $stable(out_data)));
endmodule

bind iec_subframe_packer iec_subframe_packer_chk #(
  .MAX_CH(MAX_CH), .FRAMES(FRAMES)
) chk_i (
  .clk(clk), .rst(rst), .restart(restart), .cfg_mode(cfg_mode),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .ch_pos(trk_ch), .frame_idx(trk_frame)
);

// File: tb/iec_subframe_packer_tb.sv
module iec_subframe_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [3:0]  cfg_chans = 4'd2;
  logic [31:0] cfg_status = 32'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = 32'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  iec_subframe_packer dut_i (
    .clk(clk), .rst(rst), .restart(restart), .cfg_mode(cfg_mode),
    .cfg_chans(cfg_chans), .cfg_status(cfg_status),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] gen(input int i);
    logic [31:0] v;
    v = 32'(i) * 32'h9E3779B1;
    return v ^ {v[15:0], v[31:16]} ^ 32'(i);
  endfunction

  task automatic check(input logic ok, input string what, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", what, tag, act, exp);
    end
  endtask

  task automatic check_word(input int k, input logic [31:0] w, input string tag);
    int n, ch, fr;
    logic [31:0] d;
    logic c, b, p;
    logic [31:0] exp;
    // R9: clamp channel count
    n  = (cfg_chans < 2) ? 2 : ((cfg_chans > 8) ? 8 : int'(cfg_chans));
    ch = k % n;
    fr = (k / n) % 192;
    d  = gen(k);
    if (cfg_mode) begin
      exp = {3'b000, d[3], d[31:28], d[27:4]};
      check(w == exp, "R8 pass-through relocation", tag, w, exp);
    end else begin
      if (fr >= 20 && fr <= 23) c = ((ch + 1) >> (fr - 20)) & 1;
      else if (fr < 32)         c = cfg_status[fr];
      else                      c = 1'b0;
      b = (fr == 0) && (ch == 0);
      p = ^{c, d[23:0]};
      check(w[23:0] == d[23:0] && w[31:29] == 3'b000, "R1 sample field", tag,
            w, {8'h00, d[23:0]});
      check(w[25:24] == 2'b00, "R2 V/U", tag, 32'(w[25:24]), 32'h0);
      if (fr >= 20 && fr <= 23)
        check(w[26] == c, "R4 channel number C", tag, 32'(w[26]), 32'(c));
      else
        check(w[26] == c, "R3 status C", tag, 32'(w[26]), 32'(c));
      check(w[27] == p, "R5 parity", tag, 32'(w[27]), 32'(p));
      check(w[28] == b, "R6 R7 block start", tag, 32'(w[28]), 32'(b));
    end
  endtask

  task automatic run_stream(input int n, input bit stall, input string tag);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          in_valid = 1'b1;
          in_data  = gen(i);
          #2;
          while (!in_ready) begin
            @(negedge clk);
            #2;
          end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        int k = 0;
        int cyc = 0;
        while (k < n) begin
          @(negedge clk);
          out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
          cyc++;
          #1;
          if (out_valid && out_ready) begin
            check_word(k, out_data, tag);
            k++;
          end
        end
      end
    join
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog R11 act=%h exp=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R11 reset out_valid", "reset", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R11 reset in_ready", "reset", 32'(in_ready), 32'h1);

    // PCM, two channels, across a block wrap (R7)
    cfg_mode = 1'b0; cfg_chans = 4'd2; cfg_status = 32'hA5C3_0F69;
    pulse_restart();
    run_stream(400, 1'b0, "pcm2");

    // PCM, five channels, different status, with stalls (R11)
    cfg_chans = 4'd5; cfg_status = 32'h5A3C_F096;
    pulse_restart();
    run_stream(1000, 1'b1, "R11 pcm5 stall");

    // PCM, eight channels, stalls across boundaries
    cfg_chans = 4'd8; cfg_status = 32'hFFFF_FFFF;
    pulse_restart();
    run_stream(1600, 1'b1, "R11 pcm8 stall");

    // channel count clamps (R9)
    cfg_chans = 4'd1; cfg_status = 32'h0123_4567;
    pulse_restart();
    run_stream(400, 1'b0, "R9 clamp low");
    cfg_chans = 4'd12;
    pulse_restart();
    run_stream(1600, 1'b1, "R9 clamp high");

    // pass-through (R8)
    cfg_mode = 1'b1; cfg_chans = 4'd6;
    pulse_restart();
    run_stream(500, 1'b1, "R8 pass");

    // restart with a word held in the output register (R10)
    cfg_mode = 1'b0; cfg_chans = 4'd4; cfg_status = 32'h00F0_0001;
    pulse_restart();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = 32'hDEAD_BEEF;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R10 held word present", "restart", 32'(out_valid), 32'h1);
    restart = 1'b1;
    #1;
    check(in_ready == 1'b0, "R10 no accept during restart", "restart",
          32'(in_ready), 32'h0);
    @(negedge clk);
    restart   = 1'b0;
    out_ready = 1'b1;
    #1;
    check(out_valid == 1'b0, "R10 output flushed", "restart", 32'(out_valid), 32'h0);

    // partial frame, then restart: numbering starts again at ch 0 frame 0
    run_stream(3, 1'b0, "R10 partial");
    pulse_restart();
    run_stream(200, 1'b0, "R10 after restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule